// File: doc/BRIEF.md
# Sprint-Level Router Activation Controller

This block turns a requested sprint level into power enables for the routers of a 4x4 mesh. The level is the number of cores that should run. Nodes are numbered row by row from the top-left corner: node index = row*4 + column. Node 0 in that corner is the master node, and it is always on. Further nodes join in order of their squared distance from the master node (dx² + dy²). When two nodes are at the same distance, the lower index joins first. This gives the order 0, 1, 4, 5, 2, 8, 6, 9, 10, 3, 12, 7, 13, 11, 14, 15.

For each router the block also produces two bits: one that says whether the router is linked to its east neighbour, and one for its west neighbour. The routing logic uses these bits to keep packets inside the active region. A gate-off vector marks every inactive router for power gating.

A request is a level value presented with a one-cycle valid strobe. The enable mask, both link vectors and the gate-off vector change together on the clock edge that samples the strobe. A done pulse on that same edge tells the power sequencer that new masks are ready.

Top module: `sprint_act_ctrl`

## Requirements
- R1: After synchronous reset, en_mask is 0x0001, so only node 0 is on. Both link vectors are zero, gate_off is 0xFFFE and done is 0.
- R2: A request for level N, with N from 1 to 16, enables exactly the first N nodes of the activation order. Bit n of every vector belongs to node n = row*4 + column.
- R3: Equal distances are broken by lower index first. Level 3 gives mask 0x0013 (nodes 0, 1 and 4). Level 4 gives 0x0033, which adds node 5 and leaves node 2 off.
- R4: A level of 0 is treated as 1. Any level above 16 is treated as 16.
- R5: link_east[n] is 1 exactly when node n and node n+1 are both enabled and node n is not in column 3. Bits 3, 7, 11 and 15 are always 0.
- R6: link_west[n] is 1 exactly when node n and node n-1 are both enabled and node n is not in column 0. Bits 0, 4, 8 and 12 are always 0.
- R7: gate_off is the bitwise inverse of en_mask at all times.
- R8: A request with req_valid high updates all output vectors on the edge that samples it. done is high for exactly the cycle after that edge.
- R9: While req_valid is low, changes on req_level have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Strobe that accepts req_level |
| req_level | input | 5 | Requested number of active cores |
| en_mask | output | 16 | Router/core enable, one bit per node |
| link_east | output | 16 | Per-router east connectivity bit |
| link_west | output | 16 | Per-router west connectivity bit |
| gate_off | output | 16 | Per-router power-gate request |
| done | output | 1 | One-cycle pulse after an accepted request |

## Verification
Some properties are checked on every cycle: the master bit stays on, the popcount of the mask matches the clamped level after each strobe, the link bits are a subset of enabled neighbour pairs and stay zero on the grid edges, gate_off and en_mask are exact complements, done is tied to the strobe, and the outputs hold between strobes. Other properties need the bench's scenarios. These are the exact membership of each prefix, the tie-break choices at levels 3 and 4, and the full equality of the link vectors with values derived from the expected mask. A popcount check alone cannot tell node 2 from node 5.

// File: rtl/sprint_act_pkg.sv
package sprint_act_pkg;

    localparam int unsigned MESH_COLS = 4;
    localparam int unsigned MESH_ROWS = 4;
    localparam int unsigned NODE_CNT  = MESH_COLS * MESH_ROWS;
    localparam int unsigned LEVEL_W   = $clog2(NODE_CNT + 1);

    typedef logic [NODE_CNT-1:0] node_vec_t;

    typedef struct packed {
        node_vec_t en;
        node_vec_t link_e;
        node_vec_t link_w;
    } sprint_state_t;

    // squared distance of node n from the master corner (column 0, row 0)
    function automatic int unsigned sq_dist(input int unsigned n, input int unsigned cols);
        int unsigned x;
        int unsigned y;
        x = n % cols;
        y = n / cols;
        return x * x + y * y;
    endfunction

    // position of node n in the activation order: nearer first, lower index on ties
    function automatic int unsigned act_rank(input int unsigned n, input int unsigned cols,
                                             input int unsigned nodes);
        int unsigned r;
        int unsigned dn;
        r  = 0;
        dn = sq_dist(n, cols);
        for (int unsigned m = 0; m < nodes; m++) begin
            if ((sq_dist(m, cols) < dn) || ((sq_dist(m, cols) == dn) && (m < n)))
                r++;
        end
        return r;
    endfunction

endpackage

// File: rtl/sprint_level_clamp.sv
module sprint_level_clamp #(
    parameter int unsigned NODES = sprint_act_pkg::NODE_CNT,
    parameter int unsigned LW    = $clog2(NODES + 1)
) (
    input  logic [LW-1:0] raw_level,
    output logic [LW-1:0] safe_level
);
    localparam logic [LW-1:0] MAX_LVL = LW'(NODES);

    always_comb begin
        if (raw_level == '0)
            safe_level = LW'(1);
        else if (raw_level > MAX_LVL)
            safe_level = MAX_LVL;
        else
            safe_level = raw_level;
    end
endmodule

// File: rtl/sprint_order_mask.sv
module sprint_order_mask #(
    parameter int unsigned COLS = sprint_act_pkg::MESH_COLS,
    parameter int unsigned ROWS = sprint_act_pkg::MESH_ROWS,
    parameter int unsigned NODES = COLS * ROWS,
    parameter int unsigned LW    = $clog2(NODES + 1)
) (
    input  logic [LW-1:0]    level,
    output logic [NODES-1:0] en
);
    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int unsigned RANK = sprint_act_pkg::act_rank(n, COLS, NODES);
        assign en[n] = (LW'(RANK) < level);
    end
endmodule

// File: rtl/sprint_link_bits.sv
module sprint_link_bits #(
    parameter int unsigned COLS = sprint_act_pkg::MESH_COLS,
    parameter int unsigned ROWS = sprint_act_pkg::MESH_ROWS,
    parameter int unsigned NODES = COLS * ROWS
) (
    input  logic [NODES-1:0] en,
    output logic [NODES-1:0] link_e,
    output logic [NODES-1:0] link_w
);
    for (genvar n = 0; n < NODES; n++) begin : g_node
        if ((n % COLS) == COLS - 1) begin : g_east_edge
            assign link_e[n] = 1'b0;
        end else begin : g_east
            assign link_e[n] = en[n] & en[n+1];
        end
        if ((n % COLS) == 0) begin : g_west_edge
            assign link_w[n] = 1'b0;
        end else begin : g_west
            assign link_w[n] = en[n] & en[n-1];
        end
    end
endmodule

// File: rtl/sprint_act_ctrl.sv
module sprint_act_ctrl
    import sprint_act_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [LEVEL_W-1:0]  req_level,
    output logic [NODE_CNT-1:0] en_mask,
    output logic [NODE_CNT-1:0] link_east,
    output logic [NODE_CNT-1:0] link_west,
    output logic [NODE_CNT-1:0] gate_off,
    output logic                done
);
    localparam sprint_state_t RESET_STATE = '{en: NODE_CNT'(1), link_e: '0, link_w: '0};

    logic [LEVEL_W-1:0] safe_level;
    sprint_state_t      next_state;
    sprint_state_t      cur_state;
    logic               done_q;

    sprint_level_clamp #(.NODES(NODE_CNT), .LW(LEVEL_W)) u_clamp (
        .raw_level  (req_level),
        .safe_level (safe_level)
    );

    sprint_order_mask #(.COLS(MESH_COLS), .ROWS(MESH_ROWS), .NODES(NODE_CNT), .LW(LEVEL_W)) u_order (
        .level (safe_level),
        .en    (next_state.en)
    );

    sprint_link_bits #(.COLS(MESH_COLS), .ROWS(MESH_ROWS), .NODES(NODE_CNT)) u_links (
        .en     (next_state.en),
        .link_e (next_state.link_e),
        .link_w (next_state.link_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= RESET_STATE;
            done_q    <= 1'b0;
        end else begin
            done_q <= req_valid;
            if (req_valid)
                cur_state <= next_state;
        end
    end

    assign en_mask   = cur_state.en;
    assign link_east = cur_state.link_e;
    assign link_west = cur_state.link_w;
    assign gate_off  = ~cur_state.en;
    assign done      = done_q;
endmodule

// File: rtl/sprint_act_chk.sv
module sprint_act_chk
    import sprint_act_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [LEVEL_W-1:0]  req_level,
    input logic [NODE_CNT-1:0] en_mask,
    input logic [NODE_CNT-1:0] link_east,
    input logic [NODE_CNT-1:0] link_west,
    input logic [NODE_CNT-1:0] gate_off,
    input logic                done
);
    function automatic node_vec_t col_mask(input int unsigned col);
        node_vec_t m;
        m = '0;
        for (int unsigned n = 0; n < NODE_CNT; n++)
            if ((n % MESH_COLS) == col) m[n] = 1'b1;
        return m;
    endfunction

    function automatic int unsigned clamp_lvl(input logic [LEVEL_W-1:0] l);
        if (l == '0) return 1;
        if (int'(l) > int'(NODE_CNT)) return NODE_CNT;
        return int'(l);
    endfunction

    localparam node_vec_t EAST_EDGE = col_mask(MESH_COLS - 1);
    localparam node_vec_t WEST_EDGE = col_mask(0);

    // R1
    master_on_chk: assert property (@(posedge clk) disable iff (rst) en_mask[0]);

    // R4
    level_count_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ($countones(en_mask) == clamp_lvl($past(req_level))));

    // R5
    east_link_chk: assert property (@(posedge clk) disable iff (rst)
        ((link_east & ~(en_mask & (en_mask >> 1))) == '0) && ((link_east & EAST_EDGE) == '0));

    // R6
    west_link_chk: assert property (@(posedge clk) disable iff (rst)
        ((link_west & ~(en_mask & (en_mask << 1))) == '0) && ((link_west & WEST_EDGE) == '0));

    // R7
    gate_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        ((gate_off & en_mask) == '0) && ((gate_off | en_mask) == '1));

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(req_valid));

    // R8
    done_follow_chk: assert property (@(posedge clk) disable iff (rst) req_valid |=> done);

    // R9
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(en_mask) && $stable(link_east) && $stable(link_west)));
endmodule

bind sprint_act_ctrl sprint_act_chk u_sprint_act_chk (.*);

// File: tb/sprint_act_ctrl_bench.sv
`timescale 1ns/1ps
module sprint_act_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [4:0]  req_level = '0;
    logic [15:0] en_mask, link_east, link_west, gate_off;
    logic        done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // expected activation order written out from the distance rule
    int ord [16] = '{0, 1, 4, 5, 2, 8, 6, 9, 10, 3, 12, 7, 13, 11, 14, 15};

    always #2.5 clk = ~clk;

    sprint_act_ctrl u_sprint_act_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .en_mask(en_mask), .link_east(link_east), .link_west(link_west),
        .gate_off(gate_off), .done(done)
    );

    function automatic logic [15:0] exp_mask(input int lvl);
        logic [15:0] m = '0;
        int n = lvl < 1 ? 1 : (lvl > 16 ? 16 : lvl);
        for (int i = 0; i < n; i++) m[ord[i]] = 1'b1;
        return m;
    endfunction

    function automatic logic [15:0] exp_east(input logic [15:0] m);
        logic [15:0] e = '0;
        for (int n = 0; n < 16; n++) if ((n % 4) != 3) e[n] = m[n] & m[n+1];
        return e;
    endfunction

    function automatic logic [15:0] exp_west(input logic [15:0] m);
        logic [15:0] w = '0;
        for (int n = 0; n < 16; n++) if ((n % 4) != 0) w[n] = m[n] & m[n-1];
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_all(input string tag, input int lvl);
        logic [15:0] m = exp_mask(lvl);
        check({tag, " mask"}, en_mask, m);
        check("R5 east", link_east, exp_east(m));
        check("R6 west", link_west, exp_west(m));
        check("R7 gate", gate_off, ~m);
    endtask

    task automatic apply(input int lvl);
        @(negedge clk);
        req_valid = 1'b1;
        req_level = 5'(lvl);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 mask", en_mask, 16'h0001);
        check("R1 east", link_east, 16'h0000);
        check("R1 west", link_west, 16'h0000);
        check("R1 gate", gate_off, 16'hFFFE);
        check("R1 done", {15'b0, done}, 16'h0000);
    endtask

    task automatic t_sweep;
        for (int l = 1; l <= 16; l++) begin
            apply(l);
            check_all("R2", l);
        end
        for (int l = 15; l >= 1; l -= 5) begin
            apply(l);
            check_all("R2 down", l);
        end
    endtask

    task automatic t_ties;
        apply(3);
        check("R3 level3", en_mask, 16'h0013);
        apply(4);
        check("R3 level4", en_mask, 16'h0033);
        check("R5 level4", link_east, 16'h0011);
        check("R6 level4", link_west, 16'h0022);
    endtask

    task automatic t_clamp;
        apply(9);
        apply(0);
        check_all("R4 zero", 1);
        apply(17);
        check_all("R4 seventeen", 16);
        apply(6);
        apply(31);
        check_all("R4 max", 16);
    endtask

    task automatic t_hold;
        apply(5);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            req_level = 5'(k * 3);
        end
        @(negedge clk);
        check_all("R9 hold", 5);
        check("R9 done", {15'b0, done}, 16'h0000);
    endtask

    task automatic t_done;
        @(negedge clk);
        req_valid = 1'b1;
        req_level = 5'd7;
        check("R8 before", en_mask, exp_mask(5));
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 pulse", {15'b0, done}, 16'h0001);
        check_all("R8 update", 7);
        @(negedge clk);
        check("R8 drop", {15'b0, done}, 16'h0000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ties();
        t_sweep();
        t_clamp();
        t_hold();
        t_done();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule